// File: doc/BRIEF.md
# Calendar Real-Time Clock

This peripheral keeps a binary calendar (second, minute, hour, day of month, month, year within the century, century) and exposes it on a simple 32-bit register bus. A single-cycle `tick_i` pulse, normally once per second, moves the calendar forward by one second while the clock is enabled. Rollover runs through every field, and February length follows the Gregorian leap-year rules over the full year (century × 100 + year).

Software reads the time as two packed words: a time word and a date word. Loading a new time needs the unlock bit in the control register to be set first. Writes to either time word are dropped while the clock is locked. The control register is always writable. Two further locations, an alarm and an alarm status, are decoded but do nothing. Reads return data one cycle after the request.

Top module: `cal_rtc`

## Requirements
- R1: After reset every register is zero. The clock is disabled and locked, and a read of the time word, date word or control register returns 0.
- R2: The word index is the byte address shifted right by two. Index 0 is the time word, index 1 the date word, index 2 the alarm, index 4 control and index 5 alarm status. Reads of alarm, alarm status, any other index or an address with bits [1:0] nonzero return 0, and writes to them change nothing.
- R3: The time word holds day of month in bits [28:24], hour in [20:16], minute in [13:8] and second in [5:0], all plain binary.
- R4: The date word holds century in bits [20:16], year within the century in [14:8] and month (1 to 12) in [3:0].
- R5: Control bit 0 enables the clock and control bit 1 unlocks time writes. The control register accepts every write, and its bits [31:2] read as 0.
- R6: A write to the time or date word while the unlock bit is clear leaves the calendar and the stored word unchanged.
- R7: While enabled, a read of a time word returns the running calendar and stores it as that word's held value. While disabled, the read returns the held value: the last value written or read.
- R8: While enabled, each tick pulse advances the calendar by one second. While disabled, ticks have no effect.
- R9: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each wrap carrying into the next field.
- R10: Day wraps to 1 past the last day of the month, month wraps from 12 to 1, year wraps from 99 to 0, and each wrap carries into the next field. April, June, September and November have 30 days.
- R11: February has 29 days when the full year is divisible by 4, unless the full year is divisible by 100 and not by 400. Otherwise it has 28 days.
- R12: An accepted time-word write loads its fields into the calendar in that cycle. A tick in the same cycle is dropped.
- R13: Read data appears on `rdata_o` in the cycle after the request, with every unused bit of the time and date words at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (5) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |

## Verification
A wrong carry or a wrong month length stays hidden until the calendar crosses that boundary. The bench therefore loads values one second before each boundary, issues a single tick, and reads both words back. The error then shows on the second read after the tick. A bad lock gate or a dropped held value is invisible while live and held values match. The bench forces them apart by ticking with no read, then disabling, so the fault shows on the next disabled read.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;
  localparam int CENT_W = 5;

  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int DAY_LSB  = 24;
  localparam int MON_LSB  = 0;
  localparam int YEAR_LSB = 8;
  localparam int CENT_LSB = 16;

  localparam int IDX_TIME  = 0;
  localparam int IDX_DATE  = 1;
  localparam int IDX_ALARM = 2;
  localparam int IDX_CTRL  = 4;
  localparam int IDX_ALST  = 5;

  typedef struct packed {
    logic [CENT_W-1:0] cent;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_t;

  function automatic logic [31:0] pack_time(cal_t c);
    logic [31:0] w;
    w = '0;
    w[SEC_LSB  +: SEC_W]  = c.sec;
    w[MIN_LSB  +: MIN_W]  = c.min;
    w[HOUR_LSB +: HOUR_W] = c.hour;
    w[DAY_LSB  +: DAY_W]  = c.day;
    return w;
  endfunction

  function automatic logic [31:0] pack_date(cal_t c);
    logic [31:0] w;
    w = '0;
    w[MON_LSB  +: MON_W]  = c.mon;
    w[YEAR_LSB +: YEAR_W] = c.year;
    w[CENT_LSB +: CENT_W] = c.cent;
    return w;
  endfunction

  function automatic cal_t unpack_words(logic [31:0] t, logic [31:0] d);
    cal_t c;
    c.sec  = t[SEC_LSB  +: SEC_W];
    c.min  = t[MIN_LSB  +: MIN_W];
    c.hour = t[HOUR_LSB +: HOUR_W];
    c.day  = t[DAY_LSB  +: DAY_W];
    c.mon  = d[MON_LSB  +: MON_W];
    c.year = d[YEAR_LSB +: YEAR_W];
    c.cent = d[CENT_LSB +: CENT_W];
    return c;
  endfunction

  localparam logic [31:0] TIME_MASK = pack_time('1);
  localparam logic [31:0] DATE_MASK = pack_date('1);
endpackage

// File: rtl/cal_rtc_ctr.sv
module cal_rtc_ctr #(
  parameter int W       = 6,
  parameter int MIN_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] MIN_L = W'(MIN_VAL);

  logic [W-1:0] val_q;

  // >= so out-of-range loaded values still wrap
  assign carry_o = inc_i && (val_q >= lim_i);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_q <= '0;
    else if (ld_i)     val_q <= ld_val_i;
    else if (carry_o)  val_q <= MIN_L;
    else if (inc_i)    val_q <= val_q + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_mdays.sv
module cal_rtc_mdays
  import cal_rtc_pkg::*;
(
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0] year_i,
  input  logic [1:0]        cent_lo_i,
  output logic [DAY_W-1:0]  last_day_o
);
  logic leap;

  // 100 = 0 mod 4, so divisibility by 4 follows the year alone; year 0 needs century % 4
  assign leap = (year_i == '0) ? (cent_lo_i == 2'b00) : (year_i[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      4'd2:                      last_day_o = leap ? DAY_W'(29) : DAY_W'(28);
      4'd4, 4'd6, 4'd9, 4'd11:   last_day_o = DAY_W'(30);
      default:                   last_day_o = DAY_W'(31);
    endcase
  end
endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
  import cal_rtc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic ld_time_i,
  input  logic ld_date_i,
  input  cal_t ld_cal_i,
  output cal_t cal_o
);
  logic c_sec, c_min, c_hour, c_day, c_mon, c_year, c_cent;
  logic [DAY_W-1:0] last_day;

  cal_rtc_mdays u_mdays (
    .mon_i      (cal_o.mon),
    .year_i     (cal_o.year),
    .cent_lo_i  (cal_o.cent[1:0]),
    .last_day_o (last_day)
  );

  cal_rtc_ctr #(.W(SEC_W), .MIN_VAL(0)) u_sec (
    .clk_i, .rst_ni, .ld_i(ld_time_i), .ld_val_i(ld_cal_i.sec),
    .inc_i(adv_i), .lim_i(SEC_W'(59)), .val_o(cal_o.sec), .carry_o(c_sec));

  cal_rtc_ctr #(.W(MIN_W), .MIN_VAL(0)) u_min (
    .clk_i, .rst_ni, .ld_i(ld_time_i), .ld_val_i(ld_cal_i.min),
    .inc_i(c_sec), .lim_i(MIN_W'(59)), .val_o(cal_o.min), .carry_o(c_min));

  cal_rtc_ctr #(.W(HOUR_W), .MIN_VAL(0)) u_hour (
    .clk_i, .rst_ni, .ld_i(ld_time_i), .ld_val_i(ld_cal_i.hour),
    .inc_i(c_min), .lim_i(HOUR_W'(23)), .val_o(cal_o.hour), .carry_o(c_hour));

  cal_rtc_ctr #(.W(DAY_W), .MIN_VAL(1)) u_day (
    .clk_i, .rst_ni, .ld_i(ld_time_i), .ld_val_i(ld_cal_i.day),
    .inc_i(c_hour), .lim_i(last_day), .val_o(cal_o.day), .carry_o(c_day));

  cal_rtc_ctr #(.W(MON_W), .MIN_VAL(1)) u_mon (
    .clk_i, .rst_ni, .ld_i(ld_date_i), .ld_val_i(ld_cal_i.mon),
    .inc_i(c_day), .lim_i(MON_W'(12)), .val_o(cal_o.mon), .carry_o(c_mon));

  cal_rtc_ctr #(.W(YEAR_W), .MIN_VAL(0)) u_year (
    .clk_i, .rst_ni, .ld_i(ld_date_i), .ld_val_i(ld_cal_i.year),
    .inc_i(c_mon), .lim_i(YEAR_W'(99)), .val_o(cal_o.year), .carry_o(c_year));

  cal_rtc_ctr #(.W(CENT_W), .MIN_VAL(0)) u_cent (
    .clk_i, .rst_ni, .ld_i(ld_date_i), .ld_val_i(ld_cal_i.cent),
    .inc_i(c_year), .lim_i('1), .val_o(cal_o.cent), .carry_o(c_cent));

  // century wraps modulo its width; the carry out is not needed
  logic unused_carry;
  assign unused_carry = c_cent;
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic aligned, sel_time, sel_date, sel_ctrl;
  logic rd, wr, wr_time, wr_date;
  logic [1:0]  ctrl_q;
  logic [31:0] held_time_q, held_date_q;
  logic [31:0] live_time, live_date;
  logic adv;
  cal_t cal, ld_cal;

  assign idx      = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign sel_time = aligned && (idx == IDX_W'(IDX_TIME));
  assign sel_date = aligned && (idx == IDX_W'(IDX_DATE));
  assign sel_ctrl = aligned && (idx == IDX_W'(IDX_CTRL));

  assign rd      = req_i && !we_i;
  assign wr      = req_i && we_i;
  assign wr_time = wr && sel_time && ctrl_q[1];
  assign wr_date = wr && sel_date && ctrl_q[1];
  // a time-word write in the same cycle wins over the tick
  assign adv     = tick_i && ctrl_q[0] && !wr_time && !wr_date;

  assign ld_cal = unpack_words(wdata_i, wdata_i);

  cal_rtc_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .ld_time_i (wr_time),
    .ld_date_i (wr_date),
    .ld_cal_i  (ld_cal),
    .cal_o     (cal)
  );

  assign live_time = pack_time(cal);
  assign live_date = pack_date(cal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      held_time_q <= '0;
      held_date_q <= '0;
      rdata_o     <= '0;
    end else begin
      if (wr && sel_ctrl) ctrl_q <= wdata_i[1:0];
      if (wr_time) held_time_q <= wdata_i & TIME_MASK;
      else if (rd && sel_time && ctrl_q[0]) held_time_q <= live_time;
      if (wr_date) held_date_q <= wdata_i & DATE_MASK;
      else if (rd && sel_date && ctrl_q[0]) held_date_q <= live_date;
      if (rd) begin
        if (sel_time)      rdata_o <= ctrl_q[0] ? live_time : held_time_q;
        else if (sel_date) rdata_o <= ctrl_q[0] ? live_date : held_date_q;
        else if (sel_ctrl) rdata_o <= {30'b0, ctrl_q};
        else               rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [1:0]        ctrl_i,
  input logic [31:0]       live_time_i,
  input logic [31:0]       live_date_i
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic al, rd, wr_any_time, wr_t;
  assign idx = addr_i[ADDR_W-1:2];
  assign al  = (addr_i[1:0] == 2'b00);
  assign rd  = req_i && !we_i;
  assign wr_any_time = req_i && we_i && al &&
                       (idx == IDX_W'(IDX_TIME) || idx == IDX_W'(IDX_DATE));
  assign wr_t = req_i && we_i && al && ctrl_i[1] && idx == IDX_W'(IDX_TIME);

  p_time_unused_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && al && idx == IDX_W'(IDX_TIME)) |=> ((rdata_o & ~TIME_MASK) == 32'b0));

  p_date_unused_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && al && idx == IDX_W'(IDX_DATE)) |=> ((rdata_o & ~DATE_MASK) == 32'b0));

  p_inert_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && al && (idx == IDX_W'(IDX_ALARM) || idx == IDX_W'(IDX_ALST))) |=> (rdata_o == 32'b0));

  p_ctrl_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && al && idx == IDX_W'(IDX_CTRL)) |=> (rdata_o[31:2] == 30'b0));

  p_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any_time && !ctrl_i[1] && !(tick_i && ctrl_i[0]))
      |=> ($stable(live_time_i) && $stable(live_date_i)));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && !(wr_any_time && ctrl_i[1]))
      |=> ($stable(live_time_i) && $stable(live_date_i)));

  p_sec_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && tick_i && !(wr_any_time && ctrl_i[1]) && live_time_i[5:0] == 6'd59)
      |=> (live_time_i[5:0] == 6'd0));

  p_write_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_t && tick_i) |=> (live_time_i == ($past(wdata_i) & TIME_MASK)));
endmodule

bind cal_rtc cal_rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .ctrl_i      (ctrl_q),
  .live_time_i (live_time),
  .live_date_i (live_date)
);

// File: tb/sim_cal_rtc.sv
module sim_cal_rtc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_rtc #(.ADDR_W(5)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [31:0] pk_t(int d, int h, int mi, int s);
    return 32'((d << 24) | (h << 16) | (mi << 8) | s);
  endfunction

  function automatic logic [31:0] pk_d(int c, int y, int mo);
    return 32'((c << 16) | (y << 8) | mo);
  endfunction

  function automatic int mdays(int c, int y, int m);
    int full;
    bit leap;
    full = c * 100 + y;
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (m == 2) return leap ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] step(int c, int y, int mo, int d, int h, int mi, int s);
    s++;
    if (s > 59) begin
      s = 0; mi++;
      if (mi > 59) begin
        mi = 0; h++;
        if (h > 23) begin
          h = 0;
          if (d >= mdays(c, y, mo)) begin
            d = 1; mo++;
            if (mo > 12) begin
              mo = 1; y++;
              if (y > 99) begin y = 0; c++; end
            end
          end else d++;
        end
      end
    end
    return {pk_d(c, y, mo), pk_t(d, h, mi, s)};
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(5'h00, v); chk("R1 time", v, 32'h0);
    bus_rd(5'h04, v); chk("R1 date", v, 32'h0);
    bus_rd(5'h10, v); chk("R1 ctrl", v, 32'h0);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    bus_wr(5'h10, 32'h1);
    bus_wr(5'h00, pk_t(5, 6, 7, 8));
    bus_wr(5'h04, pk_d(20, 1, 3));
    bus_rd(5'h00, v); chk("R6 time locked", v, 32'h0);
    bus_rd(5'h04, v); chk("R6 date locked", v, 32'h0);
  endtask

  task automatic t_layout;
    logic [31:0] v;
    bus_wr(5'h10, 32'hFFFF_FFFF);
    bus_rd(5'h10, v); chk("R5 ctrl bits", v, 32'h3);
    bus_wr(5'h00, 32'hE0E0_C0C0 | pk_t(15, 10, 20, 30));
    bus_rd(5'h00, v); chk("R3 R13 time fields", v, 32'h0F0A_141E);
    bus_wr(5'h04, 32'hFFE0_80F0 | pk_d(20, 24, 2));
    bus_rd(5'h04, v); chk("R4 R13 date fields", v, 32'h0014_1802);
  endtask

  task automatic t_inert;
    logic [31:0] v;
    bus_wr(5'h08, 32'hFFFF_FFFF);
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_wr(5'h01, pk_t(1, 1, 1, 1));
    bus_rd(5'h08, v); chk("R2 alarm reads 0", v, 32'h0);
    bus_rd(5'h14, v); chk("R2 status reads 0", v, 32'h0);
    bus_rd(5'h0C, v); chk("R2 gap reads 0", v, 32'h0);
    bus_rd(5'h01, v); chk("R2 unaligned reads 0", v, 32'h0);
    bus_rd(5'h00, v); chk("R2 time untouched", v, pk_t(15, 10, 20, 30));
    bus_rd(5'h10, v); chk("R2 ctrl untouched", v, 32'h3);
  endtask

  task automatic t_tick;
    logic [31:0] v;
    bus_wr(5'h00, pk_t(15, 10, 20, 30));
    ticks(5);
    bus_rd(5'h00, v); chk("R8 five ticks", v, pk_t(15, 10, 20, 35));
  endtask

  task automatic t_held;
    logic [31:0] v;
    logic [31:0] x;
    x = pk_t(3, 4, 5, 6);
    bus_wr(5'h10, 32'h2);
    bus_wr(5'h00, x);
    ticks(3);
    bus_rd(5'h00, v); chk("R8 disabled no advance", v, x);
    bus_wr(5'h10, 32'h1);
    bus_rd(5'h00, v); chk("R7 live after enable", v, x);
    ticks(1);
    bus_rd(5'h00, v); chk("R7 live read", v, pk_t(3, 4, 5, 7));
    ticks(2);
    bus_wr(5'h10, 32'h0);
    bus_rd(5'h00, v); chk("R7 held while disabled", v, pk_t(3, 4, 5, 7));
    bus_wr(5'h10, 32'h1);
    bus_rd(5'h00, v); chk("R7 live again", v, pk_t(3, 4, 5, 9));
  endtask

  task automatic roll(string rq, int c, int y, int mo, int d, int h, int mi, int s);
    logic [31:0] v;
    logic [63:0] e;
    bus_wr(5'h10, 32'h3);
    bus_wr(5'h04, pk_d(c, y, mo));
    bus_wr(5'h00, pk_t(d, h, mi, s));
    ticks(1);
    e = step(c, y, mo, d, h, mi, s);
    bus_rd(5'h00, v); chk({rq, " time"}, v, e[31:0]);
    bus_rd(5'h04, v); chk({rq, " date"}, v, e[63:32]);
  endtask

  task automatic t_rollover;
    roll("R9 minute carry", 20, 24, 5, 10, 8, 30, 59);
    roll("R9 hour carry", 20, 24, 5, 10, 8, 59, 59);
    roll("R9 day carry", 20, 24, 5, 10, 23, 59, 59);
    roll("R10 30-day month", 20, 24, 4, 30, 23, 59, 59);
    roll("R10 31-day month", 20, 24, 7, 31, 23, 59, 59);
    roll("R10 year end", 20, 24, 12, 31, 23, 59, 59);
    roll("R10 century end", 19, 99, 12, 31, 23, 59, 59);
  endtask

  task automatic t_leap;
    roll("R11 2024 feb28", 20, 24, 2, 28, 23, 59, 59);
    roll("R11 2024 feb29", 20, 24, 2, 29, 23, 59, 59);
    roll("R11 2023 feb28", 20, 23, 2, 28, 23, 59, 59);
    roll("R11 1900 feb28", 19, 0, 2, 28, 23, 59, 59);
    roll("R11 2000 feb28", 20, 0, 2, 28, 23, 59, 59);
  endtask

  task automatic t_write_tick;
    logic [31:0] v;
    bus_wr(5'h10, 32'h3);
    bus_wr(5'h00, pk_t(2, 2, 2, 10));
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 5'h00; wdata = pk_t(2, 2, 2, 40); tick = 1'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
    bus_rd(5'h00, v); chk("R12 write beats tick", v, pk_t(2, 2, 2, 40));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_layout();
    t_inert();
    t_tick();
    t_held();
    t_rollover();
    t_leap();
    t_write_tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule